// File: doc/BRIEF.md
# Range-Doppler Frame Header and Detection Packer

This block turns one completed range-Doppler frame into a byte stream for a host link. When a frame-complete strobe arrives while the block is idle, it captures the current sub-frame enable mask and stream-enable bits. It then sends a fixed nine-byte header, followed by the frame's per-cell detection codes packed four cells to a byte. The output is a plain byte stream with valid/ready flow control. Detection codes arrive one cell at a time on their own valid/ready input, in cell order.

The header opens with a start marker and a protocol version. A flags byte follows, made from the captured mask and stream bits. After that come a running frame number and the range and Doppler bin counts. The counts are fixed by parameters. Each cell carries a two-bit confidence code. The consumer learns the size of the detection payload from the bin counts in the header.

Top module: `det_frame_streamer`

## Requirements
- R1: After reset, out_valid and det_ready are low, and the first frame sent carries frame number 0.
- R2: Header byte 0 is the start marker 0xA5, and header byte 1 is the protocol version 0x02.
- R3: Header byte 2 is {2'b00, subframe_en[2:0], stream_en[2:0]}, so all bits enabled gives 0x3F.
- R4: Header bytes 3-4 hold the frame number, bytes 5-6 the range bin count and bytes 7-8 the Doppler bin count, each as 16 bits with the high byte first.
- R5: subframe_en and stream_en are sampled only on a frame_done accepted while idle. Changes to them during a frame have no effect on that frame, and a frame_done during a frame is ignored and starts no further frame.
- R6: The detection bytes follow the header, and each byte holds four 2-bit codes (0 none, 1 candidate, 2 confirmed, 3 reserved) of consecutive cells. The earliest cell sits in bits [7:6] and the latest in bits [1:0].
- R7: When the cell count is not a multiple of four, the unused lanes of the final byte are zero.
- R8: The frame number goes up by one after each frame has been fully sent, and wraps to zero after its all-ones value.
- R9: A frame has exactly 9 + ceil(cells/4) bytes, which is 6144 detection bytes for 512 range by 48 Doppler bins.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold. det_ready stays low while the header is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | Frame-complete strobe. Starts a frame when the block is idle |
| subframe_en | input | 3 | Sub-frame enable mask, captured at frame start |
| stream_en | input | 3 | Stream-enable bits, captured at frame start |
| det_valid | input | 1 | A detection code is offered |
| det_ready | output | 1 | The block takes the offered code |
| det_code | input | 2 | Detection code of the current cell |
| out_valid | output | 1 | An output byte is offered |
| out_ready | input | 1 | The consumer takes the output byte |
| out_data | output | 8 | Output byte |

## Verification
The bench targets the cell count that is not a multiple of four. A packer that forgot to clear its accumulator there would leak stale codes into the pad lanes, and one that waited for a fourth cell would hang. A frame_done pulse sent mid-frame with different flag inputs checks the capture rule. A design that resampled the flags would corrupt byte 2, and one that queued the pulse would send an extra frame. Enough frames run through a narrowed counter to cover the wrap: an off-by-one there shows up as a wrong high or low byte of the frame number. Random stalls on both handshakes expose any byte that changes or is lost while held, and a full-size frame confirms the 6144-byte payload.

// File: rtl/det_stream_pkg.sv
package det_stream_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DET} strm_state_t;

  localparam int HDR_BYTES = 9;

  // Header byte at position idx; 16-bit fields go high byte first.
  function automatic logic [7:0] hdr_byte(
    input logic [3:0]  idx,
    input logic [7:0]  sof,
    input logic [7:0]  ver,
    input logic [5:0]  flags,
    input logic [15:0] fnum,
    input logic [15:0] nrng,
    input logic [15:0] ndop
  );
    logic [7:0] b;
    case (idx)
      4'd0:    b = sof;
      4'd1:    b = ver;
      4'd2:    b = {2'b00, flags};
      4'd3:    b = fnum[15:8];
      4'd4:    b = fnum[7:0];
      4'd5:    b = nrng[15:8];
      4'd6:    b = nrng[7:0];
      4'd7:    b = ndop[15:8];
      4'd8:    b = ndop[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // Place a 2-bit code in lane 0..3; lane 0 is the top two bits.
  function automatic logic [7:0] lane_place(input logic [1:0] code, input logic [1:0] lane);
    logic [7:0] v;
    v = {code, 6'b000000};
    return v >> {lane, 1'b0};
  endfunction

endpackage

// File: rtl/det_frame_snapshot.sv
module det_frame_snapshot #(
  parameter int FNUM_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        frame_end,
  input  logic        busy,
  input  logic [2:0]  subframe_en,
  input  logic [2:0]  stream_en,
  output logic [5:0]  flags_q,
  output logic [15:0] fnum16
);
  logic [FNUM_W-1:0] fnum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      fnum_q  <= '0;
    end else begin
      if (start)     flags_q <= {subframe_en, stream_en};
      if (frame_end) fnum_q  <= fnum_q + 1'b1;
    end
  end

  always_comb begin
    fnum16 = '0;
    fnum16[FNUM_W-1:0] = fnum_q;
  end

  // R5: captured flags do not move during an active frame
  a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(flags_q));

endmodule

// File: rtl/det_code_packer.sv
module det_code_packer #(
  parameter int CELLS = 24576
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       det_valid,
  input  logic [1:0] det_code,
  output logic       det_ready,
  input  logic       byte_taken,
  output logic [7:0] byte_data,
  output logic       byte_full,
  output logic       frame_end
);
  import det_stream_pkg::*;

  localparam int BYTES  = (CELLS + 3) / 4;
  localparam int CELL_W = $clog2(CELLS + 1);
  localparam int BYTE_W = $clog2(BYTES + 1);
  localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(CELLS - 1);
  localparam logic [CELL_W-1:0] ALL_CELLS = CELL_W'(CELLS);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BYTES - 1);

  logic [7:0]        acc;
  logic [1:0]        lane;
  logic [CELL_W-1:0] cell_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic              accept;
  logic              last_cell;

  assign det_ready = active && !byte_full;
  assign accept    = det_valid && det_ready;
  assign last_cell = (cell_cnt == LAST_CELL);
  assign byte_data = acc;
  assign frame_end = byte_taken && (byte_cnt == LAST_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      lane      <= '0;
      byte_full <= 1'b0;
      cell_cnt  <= '0;
      byte_cnt  <= '0;
    end else if (byte_taken) begin
      acc       <= '0;
      lane      <= '0;
      byte_full <= 1'b0;
      if (frame_end) begin
        cell_cnt <= '0;
        byte_cnt <= '0;
      end else begin
        byte_cnt <= byte_cnt + 1'b1;
      end
    end else if (accept) begin
      acc      <= acc | lane_place(det_code, lane);
      lane     <= lane + 1'b1;
      cell_cnt <= cell_cnt + 1'b1;
      if (lane == 2'd3 || last_cell) byte_full <= 1'b1;
    end
  end

  // R9: the last byte leaves only after every cell was consumed
  a_r9_all_cells_in: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> cell_cnt == ALL_CELLS);

endmodule

// File: rtl/det_frame_streamer.sv
module det_frame_streamer #(
  parameter int         NUM_RANGE   = 512,
  parameter int         NUM_DOPPLER = 48,
  parameter int         FNUM_W      = 16,
  parameter logic [7:0] SOF_MARK    = 8'hA5,
  parameter logic [7:0] PROTO_VER   = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic [2:0] subframe_en,
  input  logic [2:0] stream_en,
  input  logic       det_valid,
  output logic       det_ready,
  input  logic [1:0] det_code,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  import det_stream_pkg::*;

  localparam int          CELLS  = NUM_RANGE * NUM_DOPPLER;
  localparam logic [15:0] NR16   = 16'(NUM_RANGE);
  localparam logic [15:0] ND16   = 16'(NUM_DOPPLER);
  localparam logic [3:0]  HDR_LAST = 4'(HDR_BYTES - 1);

  strm_state_t state;
  logic [3:0]  hdr_idx;
  logic        start;
  logic        busy;
  logic        fire;
  logic        frame_end;
  logic [5:0]  flags_q;
  logic [15:0] fnum16;
  logic [7:0]  pk_byte;
  logic        pk_full;

  assign start = frame_done && (state == ST_IDLE);
  assign busy  = (state != ST_IDLE);
  assign fire  = out_valid && out_ready;

  det_frame_snapshot #(.FNUM_W(FNUM_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_end(frame_end), .busy(busy),
    .subframe_en(subframe_en), .stream_en(stream_en),
    .flags_q(flags_q), .fnum16(fnum16)
  );

  det_code_packer #(.CELLS(CELLS)) u_pack (
    .clk(clk), .rst_n(rst_n), .active(state == ST_DET),
    .det_valid(det_valid), .det_code(det_code), .det_ready(det_ready),
    .byte_taken(fire && state == ST_DET), .byte_data(pk_byte),
    .byte_full(pk_full), .frame_end(frame_end)
  );

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (state)
      ST_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_byte(hdr_idx, SOF_MARK, PROTO_VER, flags_q, fnum16, NR16, ND16);
      end
      ST_DET: begin
        out_valid = pk_full;
        out_data  = pk_byte;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hdr_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_HDR;
          hdr_idx <= '0;
        end
        ST_HDR: if (fire) begin
          if (hdr_idx == HDR_LAST) state <= ST_DET;
          hdr_idx <= hdr_idx + 1'b1;
        end
        ST_DET: if (frame_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: a held byte stays offered and unchanged
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10: no detection code is taken while the header goes out
  a_r10_no_det_in_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> !det_ready);

endmodule

// File: tb/test_det_frame_streamer.sv
module test_det_frame_streamer;
  localparam int NR = 5, ND = 3, CELLS = NR * ND, FW = 3;
  localparam int NBYTES = (CELLS + 3) / 4;
  localparam int FULL_TOTAL = 9 + 6144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       fd = 0, dv = 0, ordy = 0;
  logic [2:0] sub = 0, sen = 0;
  logic [1:0] dcode = 0;
  logic       dr, ov;
  logic [7:0] od;

  logic       fd_f = 0, dv_f = 0, ordy_f = 0;
  logic       dr_f, ov_f;
  logic [7:0] od_f;

  det_frame_streamer #(.NUM_RANGE(NR), .NUM_DOPPLER(ND), .FNUM_W(FW)) i_det_frame_streamer (
    .clk(clk), .rst_n(rst_n), .frame_done(fd), .subframe_en(sub), .stream_en(sen),
    .det_valid(dv), .det_ready(dr), .det_code(dcode),
    .out_valid(ov), .out_ready(ordy), .out_data(od));

  det_frame_streamer i_det_frame_streamer_full (
    .clk(clk), .rst_n(rst_n), .frame_done(fd_f), .subframe_en(3'b111), .stream_en(3'b111),
    .det_valid(dv_f), .det_ready(dr_f), .det_code(2'd2),
    .out_valid(ov_f), .out_ready(ordy_f), .out_data(od_f));

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] code_q[$];
  int hdr_left = 0;
  bit busy_m = 0;
  int fcount = 0;
  int rdy_pct = 100, val_pct = 100;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Queue the expected bytes of one frame, built straight from the requirements.
  task automatic model_frame(input logic [2:0] s, input logic [2:0] e, input int seed);
    int v;
    logic [1:0] codes[CELLS];
    for (int i = 0; i < CELLS; i++) codes[i] = 2'((i * 7 + seed) % 4);
    exp_q.push_back(8'hA5);                 tag_q.push_back("R2");
    exp_q.push_back(8'h02);                 tag_q.push_back("R2");
    exp_q.push_back(8'(s * 8 + e));         tag_q.push_back("R3");
    exp_q.push_back(8'(fcount / 256));      tag_q.push_back("R8");
    exp_q.push_back(8'(fcount % 256));      tag_q.push_back("R8");
    exp_q.push_back(8'(NR / 256));          tag_q.push_back("R4");
    exp_q.push_back(8'(NR % 256));          tag_q.push_back("R4");
    exp_q.push_back(8'(ND / 256));          tag_q.push_back("R4");
    exp_q.push_back(8'(ND % 256));          tag_q.push_back("R4");
    for (int b = 0; b < NBYTES; b++) begin
      v = 0;
      for (int j = 0; j < 4; j++) begin
        v = v * 4;
        if (b * 4 + j < CELLS) v = v + int'(codes[b * 4 + j]);
      end
      exp_q.push_back(8'(v));
      tag_q.push_back(b == NBYTES - 1 ? "R7" : "R6");
    end
    for (int i = 0; i < CELLS; i++) code_q.push_back(codes[i]);
    hdr_left = 9;
    busy_m = 1;
  endtask

  task automatic step(input bit pulse);
    logic [7:0] e;
    string t;
    @(negedge clk);
    fd    = pulse;
    ordy  = ($urandom_range(99) < rdy_pct);
    dv    = (code_q.size() > 0) && ($urandom_range(99) < val_pct);
    dcode = (code_q.size() > 0) ? code_q[0] : 2'd0;
    #1;
    if (pulse && !busy_m) model_frame(sub, sen, fcount + 1);
    if (hdr_left > 0 && dr) chk(0, "R10 det_ready in header", 1, 0);
    if (!busy_m) chk(ov == 1'b0, "R5 idle out_valid", ov, 0);
    if (ov && ordy) begin
      if (exp_q.size() == 0) chk(0, "R9 extra byte", od, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(od == e, t, od, e);
        if (hdr_left > 0) hdr_left--;
        if (exp_q.size() == 0) begin
          busy_m = 0;
          fcount = (fcount + 1) % (1 << FW);
        end
      end
    end
    if (dv && dr) void'(code_q.pop_front());
  endtask

  task automatic run_frame(input logic [2:0] s, input logic [2:0] e);
    sub = s; sen = e;
    step(1);
    for (int g = 0; g < 2000 && busy_m; g++) step(0);
    chk(!busy_m, "R9 frame completes", busy_m, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ov == 1'b0, "R1 reset out_valid", ov, 0);
    chk(dr == 1'b0, "R1 reset det_ready", dr, 0);
    chk(ov_f == 1'b0, "R1 reset out_valid full", ov_f, 0);

    // R3 all enabled -> 0x3F; R1 frame number 0
    run_frame(3'b111, 3'b111);
    // R3 distinct mask and stream bits
    run_frame(3'b101, 3'b010);

    // R5: change inputs and pulse frame_done mid-frame
    rdy_pct = 50; val_pct = 60;
    sub = 3'b011; sen = 3'b100;
    step(1);
    for (int g = 0; g < 6; g++) step(0);
    sub = 3'b000; sen = 3'b111;
    step(1);
    for (int g = 0; g < 2000 && busy_m; g++) step(0);
    for (int g = 0; g < 12; g++) step(0);
    chk(ov == 1'b0, "R5 ignored frame_done", ov, 0);

    // R10 heavy back-pressure; R8 run past the counter wrap
    rdy_pct = 25; val_pct = 40;
    for (int f = 0; f < 8; f++) run_frame(3'(f), 3'(7 - f));
    rdy_pct = 100; val_pct = 100;
    run_frame(3'b110, 3'b001);

    // R9: full-size frame, 6144 detection bytes of code 2 (0xAA)
    begin
      int cnt = 0;
      @(negedge clk); fd_f = 1; dv_f = 1; ordy_f = 1;
      @(negedge clk); fd_f = 0;
      for (int g = 0; g < 60000 && cnt < FULL_TOTAL; g++) begin
        #1;
        if (ov_f) begin
          if (cnt >= 9) chk(od_f == 8'hAA, "R6 full packing", od_f, 8'hAA);
          if (cnt == 2) chk(od_f == 8'h3F, "R3 full flags", od_f, 8'h3F);
          cnt++;
        end
        @(negedge clk);
      end
      for (int g = 0; g < 10; g++) begin
        #1;
        if (ov_f) cnt++;
        @(negedge clk);
      end
      chk(cnt == FULL_TOTAL, "R9 full byte count", cnt, FULL_TOTAL);
      dv_f = 0; ordy_f = 0;
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule